// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the operands of a memory instruction into the address presented to memory and the value the base register should take afterwards. It takes a base value, an index register value, the program counter, a 12-bit immediate magnitude, a direction bit, a shift direction and amount, and a 3-bit addressing mode. It returns the effective address, the updated base value and a flag telling the register file whether to write that base value back.

The offset is either the immediate or the index register after a logical shift. The offset is added to the base or subtracted from it. Three indexing styles are available for each offset form: the address carries the offset; the address carries the offset and the base is updated; or the address is the old base and the base is updated afterwards. A seventh mode addresses relative to the program counter, which reads eight ahead of the instruction. A parameter registers the three outputs, with a synchronous reset, or leaves the unit purely combinational. The default is registered, with one cycle of latency.

Top module: `lsagu`

## Requirements
- R1: Mode 0 (immediate, pre-indexed) and mode 3 (register, pre-indexed) give `ea_o` = base ± offset and `nbase_o` = base, with `wb_o` = 0.
- R2: Mode 1 (immediate, pre-indexed with update) and mode 4 (register, pre-indexed with update) give `ea_o` = `nbase_o` = base ± offset, with `wb_o` = 1.
- R3: Mode 2 (immediate, post-indexed) and mode 5 (register, post-indexed) give `ea_o` = the unmodified base and `nbase_o` = base ± offset, with `wb_o` = 1.
- R4: In immediate modes the offset is `imm_i` zero-extended. It is added when `up_i` = 1 and subtracted when `up_i` = 0. For example, a push of base 2012 with magnitude 4 and `up_i` = 0 in mode 1 yields 2008 for both outputs.
- R5: In register modes the offset is `idx_i` shifted logically by `shamt_i` (0 to 31). The shift is left when `shdir_i` = 0 and right, filling with zeros, when `shdir_i` = 1. The shifted value is then added or subtracted under `up_i`.
- R6: Mode 6 (PC-relative) gives `ea_o` = `pc_i` + 8 ± zero-extended `imm_i`, `nbase_o` = base and `wb_o` = 0.
- R7: Mode 7 behaves exactly as mode 0.
- R8: All sums and differences wrap modulo 2^32.
- R9: With the default registered option, outputs reflect the inputs one clock later, and a high `rst` at a rising edge clears all three outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Base register value |
| idx_i | input | 32 | Index register value |
| pc_i | input | 32 | Address of the current instruction |
| imm_i | input | 12 | Immediate offset magnitude |
| up_i | input | 1 | 1 adds the offset, 0 subtracts it |
| mode_i | input | 3 | Addressing mode code |
| shdir_i | input | 1 | Index shift direction, 0 left, 1 right |
| shamt_i | input | 5 | Index shift amount |
| ea_o | output | 32 | Effective address |
| nbase_o | output | 32 | Base value after the access |
| wb_o | output | 1 | Base writeback enable |

## Verification
The checker confirms the structure of the result on every cycle after reset. Writeback appears only for update and post-indexed codes. A post-indexed address equals the previous base. A pre-indexed update makes the address and the new base equal. The non-updating modes, including PC-relative and code 7, pass the base through unchanged. Only the bench's reference model shows that the arithmetic values are correct: shift direction and amount, the sign of the offset, the eight-byte PC advance, and wrap-around at 2^32. The bench also exercises the reset clearing.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

  typedef enum logic [2:0] {
    M_IMM_PRE   = 3'd0,
    M_IMM_UPD   = 3'd1,
    M_IMM_POST  = 3'd2,
    M_REG_PRE   = 3'd3,
    M_REG_UPD   = 3'd4,
    M_REG_POST  = 3'd5,
    M_PC_REL    = 3'd6,
    M_ALIAS_PRE = 3'd7
  } agu_mode_e;

  typedef struct packed {
    logic use_idx;
    logic upd;
    logic post;
    logic pcrel;
  } agu_ctl_t;

  function automatic agu_ctl_t agu_decode(input logic [2:0] m);
    agu_ctl_t c;
    c = '0;
    case (m)
      M_IMM_UPD:  c.upd = 1'b1;
      M_IMM_POST: begin c.upd = 1'b1; c.post = 1'b1; end
      M_REG_PRE:  c.use_idx = 1'b1;
      M_REG_UPD:  begin c.use_idx = 1'b1; c.upd = 1'b1; end
      M_REG_POST: begin c.use_idx = 1'b1; c.upd = 1'b1; c.post = 1'b1; end
      M_PC_REL:   c.pcrel = 1'b1;
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lsagu_shift.sv
module lsagu_shift #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]  din,
  input  logic          dir_right,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  // Right shifts reuse the left-shift stages on a bit-reversed operand.
  logic [W-1:0] stage [0:SW];
  logic [W-1:0] rev_in, rev_out;

  generate
    for (genvar b = 0; b < W; b++) begin : g_rev
      assign rev_in[b]  = din[W-1-b];
      assign rev_out[b] = stage[SW][W-1-b];
    end
  endgenerate

  assign stage[0] = dir_right ? rev_in : din;

  generate
    for (genvar s = 0; s < SW; s++) begin : g_stage
      assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
    end
  endgenerate

  assign dout = dir_right ? rev_out : stage[SW];
endmodule

// File: rtl/lsagu_addsub.sv
module lsagu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         add,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;
  assign b_eff = add ? b : ~b;
  assign y     = a + b_eff + {{(W-1){1'b0}}, ~add};
endmodule

// File: rtl/lsagu_outreg.sv
module lsagu_outreg #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ea_d,
  input  logic [W-1:0] nb_d,
  input  logic         wb_d,
  output logic [W-1:0] ea_q,
  output logic [W-1:0] nb_q,
  output logic         wb_q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          ea_q <= '0;
          nb_q <= '0;
          wb_q <= 1'b0;
        end else begin
          ea_q <= ea_d;
          nb_q <= nb_d;
          wb_q <= wb_d;
        end
      end
    end else begin : g_comb
      assign ea_q = ea_d;
      assign nb_q = nb_d;
      assign wb_q = wb_d;
    end
  endgenerate
endmodule

// File: rtl/lsagu.sv
module lsagu
  import lsagu_pkg::*;
#(
  parameter int W         = 32,
  parameter int IMM_W     = 12,
  parameter int SH_W      = 5,
  parameter int PC_AHEAD  = 8,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     idx_i,
  input  logic [W-1:0]     pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             up_i,
  input  logic [2:0]       mode_i,
  input  logic             shdir_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [W-1:0]     ea_o,
  output logic [W-1:0]     nbase_o,
  output logic             wb_o
);
  localparam logic [W-1:0] PC_ADV = W'(PC_AHEAD);

  agu_ctl_t     ctl;
  logic [W-1:0] idx_sh, imm_ext, offset, anchor, sum;
  logic [W-1:0] ea_d, nb_d;
  logic         wb_d;

  assign ctl     = agu_decode(mode_i);
  assign imm_ext = {{(W-IMM_W){1'b0}}, imm_i};

  lsagu_shift #(.W(W), .SW(SH_W)) u_shift (
    .din(idx_i), .dir_right(shdir_i), .amt(shamt_i), .dout(idx_sh)
  );

  assign offset = ctl.use_idx ? idx_sh : imm_ext;
  assign anchor = ctl.pcrel ? (pc_i + PC_ADV) : base_i;

  lsagu_addsub #(.W(W)) u_sum (
    .a(anchor), .b(offset), .add(up_i), .y(sum)
  );

  always_comb begin
    ea_d = ctl.post ? base_i : sum;
    nb_d = ctl.upd ? sum : base_i;
    wb_d = ctl.upd & ~ctl.pcrel;
  end

  lsagu_outreg #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst),
    .ea_d(ea_d), .nb_d(nb_d), .wb_d(wb_d),
    .ea_q(ea_o), .nb_q(nbase_o), .wb_q(wb_o)
  );
endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] base_i,
  input logic [2:0]   mode_i,
  input logic [W-1:0] ea_o,
  input logic [W-1:0] nbase_o,
  input logic         wb_o
);
  generate
    if (REG_OUT) begin : g_seq
      // R2 R3: writeback only follows update or post-indexed codes
      p_wb_upd_only_r2: assert property (@(posedge clk) disable iff (rst)
        (wb_o && !$past(rst)) |->
          ($past(mode_i) inside {3'd1, 3'd2, 3'd4, 3'd5}));
      // R3: post-indexed address is the previous base
      p_post_ea_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode_i) == 3'd2 || $past(mode_i) == 3'd5)) |->
          (ea_o == $past(base_i) && wb_o));
      // R2: pre-indexed update gives equal address and new base
      p_upd_same_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode_i) == 3'd1 || $past(mode_i) == 3'd4)) |->
          (ea_o == nbase_o && wb_o));
      // R1 R6 R7: non-updating codes pass the base through
      p_keep_base_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode_i) inside {3'd0, 3'd3, 3'd6, 3'd7})) |->
          (nbase_o == $past(base_i) && !wb_o));
      // R6: PC-relative never writes back
      p_pcrel_nowb_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_i) == 3'd6) |-> !wb_o);
      // R9: outputs are clear the cycle after a reset edge
      p_reset_clear_r9: assert property (@(posedge clk)
        $past(rst) |-> (ea_o == '0 && nbase_o == '0 && !wb_o));
    end
  endgenerate
endmodule

bind lsagu lsagu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .base_i(base_i), .mode_i(mode_i),
  .ea_o(ea_o), .nbase_o(nbase_o), .wb_o(wb_o)
);

// File: tb/lsagu_test.sv
module lsagu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_i = '0, idx_i = '0, pc_i = '0;
  logic [11:0] imm_i = '0;
  logic        up_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        shdir_i = 1'b0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] ea_o, nbase_o;
  logic        wb_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsagu uut (
    .clk(clk), .rst(rst), .base_i(base_i), .idx_i(idx_i), .pc_i(pc_i),
    .imm_i(imm_i), .up_i(up_i), .mode_i(mode_i), .shdir_i(shdir_i),
    .shamt_i(shamt_i), .ea_o(ea_o), .nbase_o(nbase_o), .wb_o(wb_o)
  );

  // pending expectation (one-cycle latency)
  bit          pend = 0;
  logic [31:0] x_ea, x_nb;
  logic        x_wb;
  string       x_tag;

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd3: return "R1";
      3'd1, 3'd4: return "R2";
      3'd2, 3'd5: return "R3";
      3'd6:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(input string t, input string what,
                       input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (pend) begin
      check(x_tag, "ea", ea_o, x_ea);
      check(x_tag, "nbase", nbase_o, x_nb);
      check(x_tag, "wb", wb_o, x_wb);
    end
  endtask

  // reference model: behavioural, 64-bit arithmetic masked to 32 bits
  task automatic model(input string t);
    longint off, anch, s;
    bit reg_form, upd, post, pcrel;
    reg_form = (mode_i >= 3 && mode_i <= 5);
    upd  = (mode_i == 1 || mode_i == 2 || mode_i == 4 || mode_i == 5);
    post = (mode_i == 2 || mode_i == 5);
    pcrel = (mode_i == 6);
    if (reg_form)
      off = shdir_i ? (longint'(idx_i) >> shamt_i)
                    : ((longint'(idx_i) << shamt_i) & 64'hFFFF_FFFF);
    else
      off = longint'(imm_i);
    anch = pcrel ? longint'(pc_i) + 8 : longint'(base_i);
    s = (up_i ? anch + off : anch - off) & 64'hFFFF_FFFF;
    x_ea  = post ? base_i : s[31:0];
    x_nb  = upd ? s[31:0] : base_i;
    x_wb  = upd;
    x_tag = t;
    pend  = 1;
  endtask

  task automatic step(input string t, input logic [2:0] m, input logic [31:0] b,
                      input logic [31:0] ix, input logic [31:0] pc,
                      input logic [11:0] im, input logic up,
                      input logic sd, input logic [4:0] sa);
    @(negedge clk);
    compare_pending();
    mode_i = m; base_i = b; idx_i = ix; pc_i = pc; imm_i = im;
    up_i = up; shdir_i = sd; shamt_i = sa;
    model(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "ea reset", ea_o, 0);
    check("R9", "nbase reset", nbase_o, 0);
    check("R9", "wb reset", wb_o, 0);
    rst = 1'b0;
    model("R9");
    // directed cases
    step("R1", 3'd0, 32'd1000, 0, 0, 12'd52, 1, 0, 0);
    step("R4", 3'd1, 32'd2012, 0, 0, 12'd4, 0, 0, 0);       // push
    step("R3", 3'd2, 32'd1000, 0, 0, 12'd100, 1, 0, 0);
    step("R5", 3'd5, 32'd1000, 32'd25, 0, 0, 1, 0, 5'd2);   // post, x4
    step("R5", 3'd3, 32'd1000, 32'd200, 0, 0, 1, 0, 5'd0);
    step("R5", 3'd4, 32'd5000, 32'h8000_0000, 0, 0, 0, 1, 5'd31);
    step("R5", 3'd3, 32'd0, 32'hF0F0_1234, 0, 0, 1, 1, 5'd4);
    step("R5", 3'd3, 32'd0, 32'hFFFF_FFFF, 0, 0, 1, 0, 5'd31);
    step("R6", 3'd6, 32'd777, 0, 32'd1000, 12'd52, 1, 0, 0);  // ea 1060
    step("R6", 3'd6, 32'd777, 0, 32'd1000, 12'd8, 0, 0, 0);   // ea 1000
    step("R7", 3'd7, 32'd400, 32'd9, 0, 12'd11, 0, 1, 5'd3);
    step("R8", 3'd1, 32'hFFFF_FFFC, 0, 0, 12'd8, 1, 0, 0);
    step("R8", 3'd0, 32'd2, 0, 0, 12'hFFF, 0, 0, 0);
    step("R8", 3'd6, 0, 0, 32'hFFFF_FFFC, 12'd0, 1, 0, 0);
    // R9: reset mid-stream clears outputs
    @(negedge clk);
    compare_pending();
    rst = 1'b1; pend = 0;
    @(negedge clk);
    check("R9", "ea reset mid", ea_o, 0);
    check("R9", "wb reset mid", wb_o, 0);
    rst = 1'b0;
    model("R9");
    // pseudo-random sweep
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      step(tag_of(m), m, $urandom, $urandom, $urandom, 12'($urandom),
           1'($urandom), 1'($urandom), 5'($urandom));
    end
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule